// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Unit

This unit sits between a CPU register interface and the shift logic of a synchronous serial port. It holds a transmit queue that the CPU fills and the shifter drains, a receive queue that the shifter fills and the CPU drains, and a single-entry register for received control words. It watches the occupancy of both queues and drives empty, full and transfer-request flags from them, plus three interrupt lines.

The transfer-request flags compare free space on the transmit side, and stored words on the receive side, against watermarks that software programs. Each request flag has a dead band at the watermark value. A request is raised when the compared quantity is strictly above the watermark and dropped when it is strictly below it. While the quantity equals the watermark, the flag keeps its previous value.

Every flag on the transmit side is forced to zero while transmit is disabled, and every flag on the receive side is forced to zero while receive is disabled. The control-word register keeps only the newest word. Its ready flag clears when the CPU reads the register.

Top module: `sio_fifo_status`

## Requirements
- R1: Transmit free space is 16 minus the transmit occupancy. While transmit is enabled, `st_tx_req` becomes 1 one cycle after free space is greater than `tx_wmark`. It becomes 0 one cycle after free space is less than `tx_wmark`, and it holds its value while the two are equal.
- R2: While receive is enabled, `st_rx_req` becomes 1 one cycle after the receive occupancy is greater than `rx_wmark`. It becomes 0 one cycle after the occupancy is less than `rx_wmark`, and it holds its value while the two are equal.
- R3: While `tx_en` is 0, `st_tx_empty` and `st_tx_req` read 0. While `rx_en` is 0, `st_rx_full`, `st_rx_req` and `st_ctl_rdy` read 0, and incoming control words are not accepted.
- R4: A control word accepted while `rx_en` is 1 is stored, and `st_ctl_rdy` becomes 1. A CPU read (`cpu_ctl_rd`) clears `st_ctl_rdy`. A newer word overwrites an unread one and the flag stays 1. When a word arrives in the same cycle as a read, the new word is stored and the flag stays 1.
- R5: `st_rx_full` is 1 while the receive queue holds 16 words. It drops as soon as a CPU read removes a word.
- R6: `st_tx_empty` is 1 while the transmit queue holds no word.
- R7: Both queues are first-in first-out, 16 words of 32 bits. A push into a full queue is dropped unless a pop happens in the same cycle. A pop from an empty queue returns 0. A push and a pop in the same cycle leave the occupancy unchanged.
- R8: Each interrupt is registered one cycle after its source. `irq_tx` follows `st_tx_req & ie_tx_req`. `irq_rx` follows `st_rx_req & ie_rx_req`. `irq_ctl` follows `(st_ctl_rdy & ie_ctl_rdy) | (st_rx_full & ie_rx_full)`.
- R9: After reset, every status flag and every interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_wmark | input | 4 | Transmit free-space watermark |
| rx_wmark | input | 4 | Receive occupancy watermark |
| ie_tx_req | input | 1 | Interrupt enable for the transmit request |
| ie_rx_req | input | 1 | Interrupt enable for the receive request |
| ie_rx_full | input | 1 | Interrupt enable for receive full |
| ie_ctl_rdy | input | 1 | Interrupt enable for control-word ready |
| cpu_tx_wr | input | 1 | CPU write strobe to the transmit queue |
| cpu_tx_wdata | input | 32 | CPU transmit write data |
| cpu_rx_rd | input | 1 | CPU read strobe that pops the receive queue |
| cpu_rx_rdata | output | 32 | Head of the receive queue, 0 when the queue is empty |
| cpu_ctl_rd | input | 1 | CPU read strobe for the control-word register |
| cpu_ctl_rdata | output | 32 | Contents of the control-word register |
| sh_tx_pop | input | 1 | Shifter takes a word from the transmit queue |
| sh_tx_data | output | 32 | Head of the transmit queue, 0 when the queue is empty |
| sh_rx_push | input | 1 | Shifter delivers a received data word |
| sh_rx_data | input | 32 | Received data word |
| sh_ctl_vld | input | 1 | Shifter delivers a received control word |
| sh_ctl_data | input | 32 | Received control word |
| st_tx_empty | output | 1 | Transmit queue empty |
| st_tx_req | output | 1 | Transmit transfer request |
| st_rx_full | output | 1 | Receive queue full |
| st_rx_req | output | 1 | Receive transfer request |
| st_ctl_rdy | output | 1 | Control-word register holds unread data |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_ctl | output | 1 | Control interrupt |

## Verification
The bench walks each request flag through its dead band, one word at a time: from above the watermark, to equal, to below, and back to equal. A design that compared without the hold band, or used the wrong inequality, would change the flag at the equal point instead of keeping its previous value. It overfills and overdrains the receive queue and pushes and pops together at full and at partial occupancy. A queue that mishandled pointers or counts would return words out of order, drop the simultaneous push, or return stale data instead of 0. It overwrites the control-word register, and also reads it in the same cycle as a new word arrives. It checks that each interrupt lags its flag by exactly one cycle. A design that let the read win, or that left an interrupt unregistered, would clear the ready flag or raise the interrupt a cycle early.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef struct packed {
        logic tx_req;
        logic rx_req;
        logic irq_tx;
        logic irq_rx;
        logic irq_ctl;
    } flag_st_t;

endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CNT_W'(DEPTH)) || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = (st_q.cnt != '0) ? st_q.mem[st_q.rp] : '0;
    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt == CNT_W'(DEPTH)) |=> (st_q.cnt == CNT_W'(DEPTH))); // R7

    AST_PUSHPOP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && st_q.cnt != '0) |=> $stable(st_q.cnt)); // R7

endmodule

// File: rtl/sfs_ctlreg.sv
module sfs_ctlreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_en,
    input  logic         vld,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         rdy
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         rdy;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) st_d.rdy = 1'b0;
        if (vld && rx_en) begin
            st_d.data = wdata;
            st_d.rdy  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.data;
    assign rdy   = st_q.rdy;

    AST_CTL_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && rx_en) |=> (st_q.rdy && st_q.data == $past(wdata))); // R4

    AST_CTL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !(vld && rx_en)) |=> !st_q.rdy); // R4

endmodule

// File: rtl/sfs_flags.sv
module sfs_flags
    import sfs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WM_W  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [WM_W-1:0]  tx_wmark,
    input  logic [WM_W-1:0]  rx_wmark,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             ctl_rdy_raw,
    input  logic             ie_tx_req,
    input  logic             ie_rx_req,
    input  logic             ie_rx_full,
    input  logic             ie_ctl_rdy,
    output logic             st_tx_empty,
    output logic             st_tx_req,
    output logic             st_rx_full,
    output logic             st_rx_req,
    output logic             st_ctl_rdy,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             irq_ctl
);

    flag_st_t         st_d, st_q;
    logic [CNT_W-1:0] tx_free, tx_wm_x, rx_wm_x;

    assign tx_free = CNT_W'(DEPTH) - tx_cnt;
    assign tx_wm_x = {{(CNT_W - WM_W){1'b0}}, tx_wmark};
    assign rx_wm_x = {{(CNT_W - WM_W){1'b0}}, rx_wmark};

    assign st_tx_empty = tx_en && (tx_cnt == '0);
    assign st_tx_req   = tx_en && st_q.tx_req;
    assign st_rx_full  = rx_en && (rx_cnt == CNT_W'(DEPTH));
    assign st_rx_req   = rx_en && st_q.rx_req;
    assign st_ctl_rdy  = rx_en && ctl_rdy_raw;

    always_comb begin
        st_d = st_q;
        if (!tx_en)                st_d.tx_req = 1'b0;
        else if (tx_free > tx_wm_x) st_d.tx_req = 1'b1;
        else if (tx_free < tx_wm_x) st_d.tx_req = 1'b0;

        if (!rx_en)                st_d.rx_req = 1'b0;
        else if (rx_cnt > rx_wm_x) st_d.rx_req = 1'b1;
        else if (rx_cnt < rx_wm_x) st_d.rx_req = 1'b0;

        st_d.irq_tx  = st_tx_req & ie_tx_req;
        st_d.irq_rx  = st_rx_req & ie_rx_req;
        st_d.irq_ctl = (st_ctl_rdy & ie_ctl_rdy) | (st_rx_full & ie_rx_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_tx  = st_q.irq_tx;
    assign irq_rx  = st_q.irq_rx;
    assign irq_ctl = st_q.irq_ctl;

    AST_TXREQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_free < tx_wm_x) |=> !st_tx_req); // R1

    AST_RXREQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_cnt > rx_wm_x && $past(rx_en)) |=> (st_rx_req || !rx_en)); // R2

    AST_IRQ_TX_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_tx_req && ie_tx_req) |=> irq_tx); // R8

    AST_IRQ_CTL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_ctl_rdy && !st_rx_full) |=> !irq_ctl); // R8

endmodule

// File: rtl/sio_fifo_status.sv
module sio_fifo_status #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int WM_W  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_en,
    input  logic            rx_en,
    input  logic [WM_W-1:0] tx_wmark,
    input  logic [WM_W-1:0] rx_wmark,
    input  logic            ie_tx_req,
    input  logic            ie_rx_req,
    input  logic            ie_rx_full,
    input  logic            ie_ctl_rdy,
    input  logic            cpu_tx_wr,
    input  logic [W-1:0]    cpu_tx_wdata,
    input  logic            cpu_rx_rd,
    output logic [W-1:0]    cpu_rx_rdata,
    input  logic            cpu_ctl_rd,
    output logic [W-1:0]    cpu_ctl_rdata,
    input  logic            sh_tx_pop,
    output logic [W-1:0]    sh_tx_data,
    input  logic            sh_rx_push,
    input  logic [W-1:0]    sh_rx_data,
    input  logic            sh_ctl_vld,
    input  logic [W-1:0]    sh_ctl_data,
    output logic            st_tx_empty,
    output logic            st_tx_req,
    output logic            st_rx_full,
    output logic            st_rx_req,
    output logic            st_ctl_rdy,
    output logic            irq_tx,
    output logic            irq_rx,
    output logic            irq_ctl
);

    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             ctl_rdy_raw;

    sfs_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n),
        .push(cpu_tx_wr), .wdata(cpu_tx_wdata),
        .pop(sh_tx_pop), .rdata(sh_tx_data), .count(tx_cnt)
    );

    sfs_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n),
        .push(sh_rx_push), .wdata(sh_rx_data),
        .pop(cpu_rx_rd), .rdata(cpu_rx_rdata), .count(rx_cnt)
    );

    sfs_ctlreg #(.W(W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .vld(sh_ctl_vld), .wdata(sh_ctl_data),
        .rd(cpu_ctl_rd), .rdata(cpu_ctl_rdata), .rdy(ctl_rdy_raw)
    );

    sfs_flags #(.DEPTH(DEPTH), .WM_W(WM_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .tx_en(tx_en), .rx_en(rx_en),
        .tx_wmark(tx_wmark), .rx_wmark(rx_wmark),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ctl_rdy_raw(ctl_rdy_raw),
        .ie_tx_req(ie_tx_req), .ie_rx_req(ie_rx_req),
        .ie_rx_full(ie_rx_full), .ie_ctl_rdy(ie_ctl_rdy),
        .st_tx_empty(st_tx_empty), .st_tx_req(st_tx_req),
        .st_rx_full(st_rx_full), .st_rx_req(st_rx_req),
        .st_ctl_rdy(st_ctl_rdy),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ctl(irq_ctl)
    );

endmodule

// File: tb/tb_sio_fifo_status.sv
module tb_sio_fifo_status;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 0, rx_en = 0;
    logic [3:0]  tx_wmark = 0, rx_wmark = 0;
    logic        ie_tx_req = 0, ie_rx_req = 0, ie_rx_full = 0, ie_ctl_rdy = 0;
    logic        cpu_tx_wr = 0, cpu_rx_rd = 0, cpu_ctl_rd = 0;
    logic [31:0] cpu_tx_wdata = 0;
    logic [31:0] cpu_rx_rdata, cpu_ctl_rdata, sh_tx_data;
    logic        sh_tx_pop = 0, sh_rx_push = 0, sh_ctl_vld = 0;
    logic [31:0] sh_rx_data = 0, sh_ctl_data = 0;
    logic        st_tx_empty, st_tx_req, st_rx_full, st_rx_req, st_ctl_rdy;
    logic        irq_tx, irq_rx, irq_ctl;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sio_fifo_status dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tx_push(input logic [31:0] v);
        cpu_tx_wr = 1; cpu_tx_wdata = v; cyc(1); cpu_tx_wr = 0;
    endtask

    task automatic tx_pop();
        sh_tx_pop = 1; cyc(1); sh_tx_pop = 0;
    endtask

    task automatic rx_push(input logic [31:0] v);
        sh_rx_push = 1; sh_rx_data = v; cyc(1); sh_rx_push = 0;
    endtask

    task automatic rx_pop();
        cpu_rx_rd = 1; cyc(1); cpu_rx_rd = 0;
    endtask

    task automatic ctl_put(input logic [31:0] v);
        sh_ctl_vld = 1; sh_ctl_data = v; cyc(1); sh_ctl_vld = 0;
    endtask

    task automatic t_reset();
        check("R9 st_tx_empty", st_tx_empty, 0);
        check("R9 st_tx_req", st_tx_req, 0);
        check("R9 st_rx_full", st_rx_full, 0);
        check("R9 st_rx_req", st_rx_req, 0);
        check("R9 st_ctl_rdy", st_ctl_rdy, 0);
        check("R9 irqs", {irq_tx, irq_rx, irq_ctl}, 0);
    endtask

    task automatic t_tx_band();
        tx_en = 1; tx_wmark = 4; cyc(2);
        check("R6 empty when tx queue empty", st_tx_empty, 1);
        check("R1 req set free16>wm4", st_tx_req, 1);
        for (int i = 0; i < 12; i++) tx_push(32'h100 + i);
        cyc(1);
        check("R1 req holds at free==wm", st_tx_req, 1);
        check("R6 not empty", st_tx_empty, 0);
        tx_push(32'h10C); cyc(1);
        check("R1 req clears free3<wm4", st_tx_req, 0);
        check("R7 tx head order", sh_tx_data, 32'h100);
        tx_pop(); cyc(1);
        check("R1 req holds low at free==wm", st_tx_req, 0);
        check("R7 tx second word", sh_tx_data, 32'h101);
        tx_pop(); cyc(1);
        check("R1 req sets again free5>wm4", st_tx_req, 1);
        for (int i = 0; i < 11; i++) tx_pop();
        cyc(1);
        check("R6 empty after drain", st_tx_empty, 1);
        check("R7 tx empty pop gives 0", sh_tx_data, 0);
        tx_en = 0; cyc(1);
        check("R3 tx_empty gated", st_tx_empty, 0);
        check("R3 tx_req gated", st_tx_req, 0);
    endtask

    task automatic t_rx_band();
        rx_en = 1; rx_wmark = 2;
        rx_push(32'h1); rx_push(32'h2); cyc(1);
        check("R2 req low at count==wm", st_rx_req, 0);
        rx_push(32'h3); cyc(1);
        check("R2 req set count3>wm2", st_rx_req, 1);
        rx_pop(); cyc(1);
        check("R2 req holds at count==wm", st_rx_req, 1);
        rx_pop(); cyc(1);
        check("R2 req clears count1<wm2", st_rx_req, 0);
        check("R7 rx order", cpu_rx_rdata, 32'h3);
        rx_pop(); cyc(1);
    endtask

    task automatic t_full();
        rx_wmark = 15;
        for (int i = 0; i < 16; i++) rx_push(32'hA000 + i);
        cyc(1);
        check("R5 full at 16", st_rx_full, 1);
        check("R2 req count16>wm15", st_rx_req, 1);
        rx_push(32'hDEAD); cyc(1);
        check("R5 still full after dropped push", st_rx_full, 1);
        rx_en = 0; cyc(1);
        check("R3 rx_full gated", st_rx_full, 0);
        check("R3 rx_req gated", st_rx_req, 0);
        rx_en = 1; cyc(1);
        check("R7 head", cpu_rx_rdata, 32'hA000);
        rx_pop();
        check("R5 full drops on read", st_rx_full, 0);
        for (int i = 1; i < 16; i++) begin
            check("R7 rx order full", cpu_rx_rdata, 32'hA000 + i);
            rx_pop();
        end
        check("R7 dropped push absent, empty reads 0", cpu_rx_rdata, 0);
        rx_pop();
        check("R7 pop from empty reads 0", cpu_rx_rdata, 0);
    endtask

    task automatic t_pushpop();
        rx_push(32'hB0); rx_push(32'hB1); rx_push(32'hB2);
        sh_rx_push = 1; sh_rx_data = 32'hB3; cpu_rx_rd = 1; cyc(1);
        sh_rx_push = 0; cpu_rx_rd = 0;
        for (int i = 1; i < 4; i++) begin
            check("R7 simul push/pop keeps words", cpu_rx_rdata, 32'hB0 + i);
            rx_pop();
        end
        check("R7 count unchanged by simul push/pop", cpu_rx_rdata, 0);
        for (int i = 0; i < 16; i++) rx_push(32'hC0 + i);
        sh_rx_push = 1; sh_rx_data = 32'hCF0; cpu_rx_rd = 1; cyc(1);
        sh_rx_push = 0; cpu_rx_rd = 0;
        check("R7 full simul push/pop stays full", st_rx_full, 1);
        for (int i = 0; i < 15; i++) rx_pop();
        check("R7 full simul push accepted", cpu_rx_rdata, 32'hCF0);
        rx_pop();
    endtask

    task automatic t_ctl();
        ctl_put(32'h11);
        check("R4 rdy set", st_ctl_rdy, 1);
        check("R4 data stored", cpu_ctl_rdata, 32'h11);
        cpu_ctl_rd = 1; cyc(1); cpu_ctl_rd = 0;
        check("R4 rdy cleared by read", st_ctl_rdy, 0);
        ctl_put(32'h22); ctl_put(32'h33);
        check("R4 overwrite keeps rdy", st_ctl_rdy, 1);
        check("R4 newest word", cpu_ctl_rdata, 32'h33);
        sh_ctl_vld = 1; sh_ctl_data = 32'h44; cpu_ctl_rd = 1; cyc(1);
        sh_ctl_vld = 0; cpu_ctl_rd = 0;
        check("R4 word wins over read", st_ctl_rdy, 1);
        check("R4 word stored with read", cpu_ctl_rdata, 32'h44);
        cpu_ctl_rd = 1; cyc(1); cpu_ctl_rd = 0;
        rx_en = 0; ctl_put(32'h55);
        check("R3 ctl_rdy gated", st_ctl_rdy, 0);
        rx_en = 1; cyc(1);
        check("R3 word ignored while disabled", cpu_ctl_rdata, 32'h44);
        check("R3 rdy not set while disabled", st_ctl_rdy, 0);
    endtask

    task automatic t_irq();
        tx_en = 1; tx_wmark = 4; cyc(3);
        check("R8 irq_tx masked", irq_tx, 0);
        ie_tx_req = 1; cyc(1);
        check("R8 irq_tx one cycle after enable", irq_tx, 1);
        ie_tx_req = 0; cyc(1);
        check("R8 irq_tx drops", irq_tx, 0);
        tx_en = 0;
        ie_ctl_rdy = 1; ctl_put(32'h66);
        check("R8 irq_ctl not yet", irq_ctl, 0);
        cyc(1);
        check("R8 irq_ctl after rdy", irq_ctl, 1);
        cpu_ctl_rd = 1; cyc(1); cpu_ctl_rd = 0; cyc(1);
        check("R8 irq_ctl clears", irq_ctl, 0);
        ie_ctl_rdy = 0; ie_rx_full = 1; ie_rx_req = 1; rx_wmark = 15;
        for (int i = 0; i < 16; i++) rx_push(i);
        check("R8 irq_ctl lag full", irq_ctl, 0);
        cyc(1);
        check("R8 irq_ctl from full", irq_ctl, 1);
        check("R8 irq_rx lag req", irq_rx, 0);
        cyc(1);
        check("R8 irq_rx from req", irq_rx, 1);
        for (int i = 0; i < 16; i++) rx_pop();
        cyc(3);
        check("R8 irq_rx clears", irq_rx, 0);
        check("R8 irq_ctl clears after read", irq_ctl, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(2);
        t_reset();
        t_tx_band();
        t_rx_band();
        t_full();
        t_pushpop();
        t_ctl();
        t_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule